// File: doc/BRIEF.md
# Ramp-Compare Hold Timing Generator

This block produces the per-channel sample-switch controls for a ramp-sampling digital-to-analog scheme. Each of the channels owns a binary level code. An external ramp is shared by all channels; every channel has a hold capacitor that follows the ramp while its sample switch is closed and keeps its voltage once the switch opens. The block decides, channel by channel, the moment the switch opens, so that the held voltage matches the channel's code.

Codes are written into a bank of input latches at any time. A load pulse works in two steps. Its leading edge moves the input latches into the comparator latches and drops every sample-enable output. Its trailing edge starts a sweep. In a sweep, a shared counter begins at zero and advances on each count tick. A channel's sample-enable stays high while the counter is below that channel's code. It falls when the counter reaches the code. The counter stops at its top value, and a done flag then reports the end of the sweep.

The whole block runs on one system clock. The load level and the count tick are sampled on that clock, and the count tick works as a clock enable for the counter. Reset is asynchronous and active low. It is released in step with the clock inside the block.

Top module: `rcg_hold_timer`

## Requirements
- R1: While reset is asserted, and after it is released with no load pulse yet seen, every bit of `samp_en` is 0 and `sweep_done` is 0.
- R2: The comparator latches take the input-latch contents on the clock edge where `load_cnt` is first seen high. A write on that same edge, or any later one, goes only to the input latches.
- R3: On the clock edge where `load_cnt` is first seen high, every `samp_en` bit and `sweep_done` are cleared, even in the middle of a sweep. They stay cleared while `load_cnt` stays high.
- R4: On the clock edge where `load_cnt` is first seen low after being high, the counter is set to 0 and a sweep starts. From that edge, each channel with a nonzero code drives its `samp_en` bit high.
- R5: During a sweep, the counter advances by exactly one on each clock edge where `cnt_tick` is high. It holds on edges where `cnt_tick` is low. It never goes past 127.
- R6: During a sweep, `samp_en[i]` is 1 exactly while the counter is below channel i's code. It goes to 0 on the edge where the counter becomes equal to the code and stays 0 for the rest of that sweep.
- R7: A channel whose code is 0 never drives its `samp_en` bit high.
- R8: Writes to the input latches during a sweep leave the running sweep's `samp_en` pattern unchanged.
- R9: `sweep_done` goes high on the edge where the counter reaches 127 during a sweep and stays high until the next load pulse. At that point every `samp_en` bit is 0.
- R10: Channel i's code sits at bits [i*7 +: 7] of `in_words`. It is stored when `in_we` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_we | input | 1 | Write strobe for all input latches |
| in_words | input | 224 | Packed channel codes, channel i at bits [i*7 +: 7] |
| load_cnt | input | 1 | Load pulse: leading edge captures and clears, trailing edge starts the sweep |
| cnt_tick | input | 1 | Count enable for the sweep counter |
| samp_en | output | 32 | Per-channel sample-switch enable |
| sweep_done | output | 1 | The sweep counter has reached its top value |

## Verification
The main sweep is driven with a spread of codes that includes 0, 1, 127 and repeated values, and `cnt_tick` is held high. This shows whether each channel's edge falls on the exact count and whether the extreme codes are handled. A second sweep gates the tick on and off in an irregular pattern, which separates a counter that follows `cnt_tick` from one that runs on every clock. Other runs write the latches on the capture edge and all through a sweep, restart a sweep partway through, and hold the load level high with ticks running. These show which latch feeds the compare, whether the leading edge clears the outputs, and that no sweep starts before the trailing edge.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  // Event decoded from the load level on each clock edge.
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_RISE = 2'd1,
    LD_FALL = 2'd2
  } ld_evt_e;

endpackage

// File: rtl/rcg_rst_sync.sv
module rcg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rcg_load_edge.sv
module rcg_load_edge
  import rcg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_lvl,
  output ld_evt_e evt
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= load_lvl;
  end

  always_comb begin
    if (load_lvl && !lvl_q)      evt = LD_RISE;
    else if (!load_lvl && lvl_q) evt = LD_FALL;
    else                         evt = LD_NONE;
  end

endmodule

// File: rtl/rcg_sweep_ctr.sv
module rcg_sweep_ctr
  import rcg_pkg::*;
#(
  parameter int unsigned VAL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ld_evt_e          evt,
  input  logic             tick,
  output logic [VAL_W-1:0] cnt_q,
  output logic [VAL_W-1:0] cnt_nxt,
  output logic             step,
  output logic             active_q,
  output logic             done_q
);

  localparam logic [VAL_W-1:0] CNT_MAX = '1;

  logic active_d;
  logic done_d;

  always_comb begin
    step     = active_q && tick && (cnt_q != CNT_MAX) && (evt == LD_NONE);
    cnt_nxt  = cnt_q;
    active_d = active_q;
    unique case (evt)
      LD_RISE: begin
        active_d = 1'b0;
      end
      LD_FALL: begin
        active_d = 1'b1;
        cnt_nxt  = '0;
      end
      default: begin
        if (step) cnt_nxt = cnt_q + 1'b1;
      end
    endcase
    done_d = active_d && (cnt_nxt == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      active_q <= active_d;
      done_q   <= done_d;
    end
  end

endmodule

// File: rtl/rcg_channel.sv
module rcg_channel
  import rcg_pkg::*;
#(
  parameter int unsigned VAL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VAL_W-1:0] wr_val,
  input  ld_evt_e          evt,
  input  logic             step,
  input  logic [VAL_W-1:0] cnt_nxt,
  output logic             samp
);

  logic [VAL_W-1:0] in_q;
  logic [VAL_W-1:0] cmp_q;
  logic             samp_q;
  logic             cmp_en;
  logic             samp_d;

  always_comb begin
    cmp_en = (evt == LD_RISE);
    unique case (evt)
      LD_RISE: samp_d = 1'b0;
      LD_FALL: samp_d = (cmp_q != '0);
      default: samp_d = samp_q && !(step && (cnt_nxt == cmp_q));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= '0;
    else if (wr_en) in_q <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_en) cmp_q <= in_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) samp_q <= 1'b0;
    else        samp_q <= samp_d;
  end

  assign samp = samp_q;

endmodule

// File: rtl/rcg_hold_timer.sv
module rcg_hold_timer
  import rcg_pkg::*;
#(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned VAL_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_we,
  input  logic [N_CH*VAL_W-1:0]   in_words,
  input  logic                    load_cnt,
  input  logic                    cnt_tick,
  output logic [N_CH-1:0]         samp_en,
  output logic                    sweep_done
);

  logic             rst_i_n;
  ld_evt_e          ld_evt;
  logic [VAL_W-1:0] cnt_q;
  logic [VAL_W-1:0] cnt_nxt;
  logic             cnt_step;
  logic             sweep_act;

  rcg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rcg_load_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load_lvl (load_cnt),
    .evt      (ld_evt)
  );

  rcg_sweep_ctr #(.VAL_W(VAL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .evt      (ld_evt),
    .tick     (cnt_tick),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .step     (cnt_step),
    .active_q (sweep_act),
    .done_q   (sweep_done)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    rcg_channel #(.VAL_W(VAL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_en   (in_we),
      .wr_val  (in_words[g*VAL_W +: VAL_W]),
      .evt     (ld_evt),
      .step    (cnt_step),
      .cnt_nxt (cnt_nxt),
      .samp    (samp_en[g])
    );
  end

endmodule

// File: rtl/rcg_hold_timer_chk.sv
module rcg_hold_timer_chk #(
  parameter int unsigned N_CH  = 32,
  parameter int unsigned VAL_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_cnt,
  input logic [N_CH-1:0]  samp_en,
  input logic             sweep_done,
  input logic [VAL_W-1:0] cnt,
  input logic             active
);

  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_cnt) |=> (samp_en == '0) && !sweep_done); // R3

  AST_FALL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_cnt) |=> !sweep_done && (cnt == '0)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && !load_cnt && !$fell(load_cnt) |=>
      (cnt == $past(cnt)) || (cnt == VAL_W'($past(cnt) + 1'b1))); // R5

  AST_NO_LATE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(load_cnt) |=> ((samp_en & ~$past(samp_en)) == '0)); // R6

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done && !load_cnt |=> sweep_done); // R9

  AST_DONE_ALL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (samp_en == '0)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (samp_en == '0) && !sweep_done); // R3

endmodule

bind rcg_hold_timer rcg_hold_timer_chk #(.N_CH(N_CH), .VAL_W(VAL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_cnt   (load_cnt),
  .samp_en    (samp_en),
  .sweep_done (sweep_done),
  .cnt        (cnt_q),
  .active     (sweep_act)
);

// File: tb/test_rcg_hold_timer.sv
`timescale 1ns/1ps
module test_rcg_hold_timer;

  localparam int N = 32;
  localparam int W = 7;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_we;
  logic [N*W-1:0] in_words;
  logic           load_cnt;
  logic           cnt_tick;
  logic [N-1:0]   samp_en;
  logic           sweep_done;

  int checks = 0;
  int fails  = 0;

  // Reference model built from the requirements.
  int m_in  [N];
  int m_cmp [N];
  int m_cnt;
  bit m_act;
  bit m_ldp;

  always #4 clk = ~clk;

  rcg_hold_timer #(.N_CH(N), .VAL_W(W)) i_rcg_hold_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_we      (in_we),
    .in_words   (in_words),
    .load_cnt   (load_cnt),
    .cnt_tick   (cnt_tick),
    .samp_en    (samp_en),
    .sweep_done (sweep_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_samp();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_act && (m_cnt < m_cmp[i]);
    return v;
  endfunction

  // One clock: drive at negedge, let the edge pass, update model, compare at next negedge.
  task automatic cyc(input bit ld, input bit tk, input bit we, input string tag);
    bit rise, fall;
    logic [N-1:0] es;
    logic ed;
    load_cnt = ld;
    cnt_tick = tk;
    in_we    = we;
    @(posedge clk);
    rise = ld && !m_ldp;
    fall = !ld && m_ldp;
    if (rise) begin
      for (int i = 0; i < N; i++) m_cmp[i] = m_in[i];
      m_act = 1'b0;
    end else if (fall) begin
      m_cnt = 0;
      m_act = 1'b1;
    end else if (m_act && tk && m_cnt < 127) begin
      m_cnt++;
    end
    if (we) for (int i = 0; i < N; i++) m_in[i] = int'(in_words[i*W +: W]);
    m_ldp = ld;
    @(negedge clk);
    es = exp_samp();
    ed = m_act && (m_cnt == 127);
    chk((samp_en === es) && (sweep_done === ed), tag, {31'd0, sweep_done, samp_en}, {31'd0, ed, es});
  endtask

  task automatic set_words(input int seed, input int mul);
    for (int i = 0; i < N; i++) in_words[i*W +: W] = W'((seed + i * mul) % 128);
  endtask

  task automatic start_sweep(input string tag);
    cyc(1'b1, 1'b0, 1'b0, tag);
    cyc(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_we = 1'b0; load_cnt = 1'b0; cnt_tick = 1'b0; in_words = '0;
    for (int i = 0; i < N; i++) begin m_in[i] = 0; m_cmp[i] = 0; end
    m_cnt = 0; m_act = 1'b0; m_ldp = 1'b0;
    repeat (3) @(negedge clk);
    chk((samp_en === '0) && (sweep_done === 1'b0), "R1 in reset", {31'd0, sweep_done, samp_en}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk((samp_en === '0) && (sweep_done === 1'b0), "R1 after release", {31'd0, sweep_done, samp_en}, 64'd0);
    cnt_tick = 1'b1;
    repeat (5) cyc(1'b0, 1'b1, 1'b0, "R1 ticks without load");
  endtask

  task automatic t_basic();
    set_words(0, 9);
    in_words[0*W +: W]  = W'(0);
    in_words[1*W +: W]  = W'(1);
    in_words[31*W +: W] = W'(127);
    in_words[30*W +: W] = W'(64);
    in_words[29*W +: W] = W'(64);
    cyc(1'b0, 1'b0, 1'b1, "R10 write");
    start_sweep("R4 sweep start");
    chk(samp_en[0] === 1'b0, "R7 zero code after start", {63'd0, samp_en[0]}, 64'd0);
    chk(samp_en[1] === 1'b1 && samp_en[31] === 1'b1, "R4 nonzero codes high", {62'd0, samp_en[31], samp_en[1]}, 64'd3);
    for (int k = 0; k < 130; k++) begin
      cyc(1'b0, 1'b1, 1'b0, "R6 continuous sweep");
      if (samp_en[0] !== 1'b0) chk(1'b0, "R7 zero code rose", {63'd0, samp_en[0]}, 64'd0);
    end
    chk(sweep_done === 1'b1, "R9 done at top", {63'd0, sweep_done}, 64'd1);
    chk(samp_en === '0, "R9 all open at done", {32'd0, samp_en}, 64'd0);
    repeat (4) cyc(1'b0, 1'b1, 1'b0, "R9 done holds");
  endtask

  task automatic t_gapped();
    set_words(127, 125);
    cyc(1'b0, 1'b0, 1'b1, "R10 write");
    start_sweep("R4 gapped start");
    for (int k = 0; k < 220; k++) cyc(1'b0, (k % 3 != 0) && (k % 7 != 5), 1'b0, "R5 gapped ticks");
    for (int k = 0; k < 60; k++) cyc(1'b0, 1'b1, 1'b0, "R5 finish");
    chk(sweep_done === 1'b1, "R5 saturated at 127", {63'd0, sweep_done}, 64'd1);
  endtask

  task automatic t_rewrite();
    set_words(5, 3);
    cyc(1'b0, 1'b0, 1'b1, "R10 write A");
    set_words(90, 1);
    cyc(1'b1, 1'b0, 1'b1, "R2 write on capture edge");
    cyc(1'b0, 1'b0, 1'b0, "R2 start with old codes");
    chk(samp_en[0] === 1'b1 && samp_en[N-1] === 1'b1, "R2 captured A", {62'd0, samp_en[N-1], samp_en[0]}, 64'd3);
    for (int k = 0; k < 135; k++) begin
      set_words(k * 7, k + 2);
      cyc(1'b0, 1'b1, 1'b1, "R8 writes during sweep");
    end
    start_sweep("R2 next sweep uses last write");
    for (int k = 0; k < 130; k++) cyc(1'b0, 1'b1, 1'b0, "R2 second sweep");
  endtask

  task automatic t_reload();
    set_words(60, 2);
    cyc(1'b0, 1'b0, 1'b1, "R10 write");
    start_sweep("R4 start");
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, 1'b0, "R6 partial sweep");
    cyc(1'b1, 1'b1, 1'b0, "R3 rise mid-sweep");
    chk((samp_en === '0) && (sweep_done === 1'b0), "R3 cleared", {31'd0, sweep_done, samp_en}, 64'd0);
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b1, 1'b0, "R3 held high stays clear");
    cyc(1'b0, 1'b1, 1'b0, "R4 restart from zero");
    for (int k = 0; k < 130; k++) cyc(1'b0, 1'b1, 1'b0, "R6 restarted sweep");
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_gapped();
    t_rewrite();
    t_reload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule